// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block counts hardware events for a shared processor cluster. It holds a parameterised number of 32-bit event counters and one free-running 64-bit cycle counter. Each event counter picks one line of an incoming event vector through its own 8-bit event-select register. Two event codes have a fixed meaning. Code 0x11 counts clock cycles. Code 0x1E, when selected on an odd counter, counts the wraps of the even counter just below it, so the two counters form a 64-bit pair.

Software reaches the unit through a simple single-cycle register port. The port has a write strobe, a read strobe, an 8-bit word address and 32-bit data. Read data is registered and appears in the cycle after the read strobe.

Every counter sets a sticky overflow bit when it wraps. A single read of the overflow register returns those bits and clears them. One level interrupt is raised while any overflow bit has its interrupt enable set.

Top module: `clu_perfmon`

## Requirements
- R1: The control register at address 0x00 reads back as follows. The global enable is in bit 0. Bits 2:1 read as zero. The event-counter count N is in bits 15:11, ID_CODE is in bits 23:16 and IMPL_CODE is in bits 31:24.
- R2: Event counter i is at address 0x20+i and its event select is at address 0x40+i. Counter i adds one on each cycle in which events[sel] is high, but only while control bit 0 and enable bit i are both 1. At any other time the counter holds its value.
- R3: The cycle counter is 64 bits wide, with its low half at address 0x08 and its high half at address 0x09. It adds one each cycle while control bit 0 and enable bit 31 are both 1. When it passes all-ones it wraps to zero and sets overflow bit 31.
- R4: Writing a 1 to a bit sets that bit in the counter-enable mask (address 0x01) or in the interrupt-enable mask (address 0x03). Writing a 1 to the clear addresses (0x02 and 0x04) clears that bit. Each pair of addresses reads back its mask. Bits N to 30 always read as 0.
- R5: An event counter whose select is 0x11 counts every enabled cycle and does not look at the event vector.
- R6: An odd counter whose select is 0x1E adds one in each cycle in which the even counter just below it wraps.
- R7: A 32-bit event counter that passes 0xFFFFFFFF wraps to 0 and sets overflow bit i. An overflow bit stays set until it is cleared by a read.
- R8: A read of address 0x05 returns the overflow bitmap and clears it. A bit that is set in the same cycle as the read is kept.
- R9: The irq output is high exactly while some overflow bit has its interrupt-enable bit set.
- R10: A write to a counter loads that value directly, and the write takes priority over counting in the same cycle. Counting then continues from the written value.
- R11: Writing control bit 1 clears every event counter. Writing control bit 2 clears only the cycle counter.
- R12: A read of the low cycle half captures the high half at that moment. A later read of address 0x09 returns that captured value.
- R13: Addresses 0x06 and 0x07 return the low and high words of the 64-bit CEID_MASK parameter. In that mask, bit k marks event code k as supported.
- R14: A counter or select address whose index is N or more ignores writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid the cycle after regRdEn |
| events | input | EVT_W | Event pulses indexed by event code |
| irq | output | 1 | Level overflow interrupt |

## Verification
The bench builds the unit with four event counters (NUM_CNT = 4), distinct ID and implementer codes, and a non-trivial CEID_MASK. With N = 4, the count field has a value the bench can tell apart, and writes of all-ones to the enable masks show the clipping of bits 4 to 30. Index 5 becomes an unimplemented address, and counters 0 and 1 give a chain pair. Counters and the cycle counter are preloaded just below their wrap point. This makes the 32-bit wrap, the chained carry and the full 64-bit wrap reachable in a few cycles, rather than after 2^32 events.

// File: rtl/perfmon_pkg.sv
`timescale 1ns/1ps
package perfmon_pkg;
  localparam int unsigned CYC_IDX = 31;
  localparam logic [7:0] EV_CYCLES = 8'h11;
  localparam logic [7:0] EV_CHAIN  = 8'h1E;

  localparam logic [7:0] ADR_CTRL    = 8'h00;
  localparam logic [7:0] ADR_EN_SET  = 8'h01;
  localparam logic [7:0] ADR_EN_CLR  = 8'h02;
  localparam logic [7:0] ADR_IRQ_SET = 8'h03;
  localparam logic [7:0] ADR_IRQ_CLR = 8'h04;
  localparam logic [7:0] ADR_OVF     = 8'h05;
  localparam logic [7:0] ADR_CEID_LO = 8'h06;
  localparam logic [7:0] ADR_CEID_HI = 8'h07;
  localparam logic [7:0] ADR_CYC_LO  = 8'h08;
  localparam logic [7:0] ADR_CYC_HI  = 8'h09;
  localparam logic [2:0] REGION_CNT  = 3'b001;
  localparam logic [2:0] REGION_SEL  = 3'b010;

  // Strobes from register control to counter datapath
  typedef struct packed {
    logic [30:0] evCntWr;
    logic        cycLoWr;
    logic        cycHiWr;
    logic        rstEv;
    logic        rstCyc;
    logic [31:0] wrData;
  } dpStrobe_t;
endpackage

// File: rtl/perfmon_ctrl.sv
`timescale 1ns/1ps
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT   = 6,
  parameter logic [7:0]  ID_CODE   = 8'h5A,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter logic [63:0] CEID_MASK = 64'h0000_1E00_6602_0000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [7:0]             regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [NUM_CNT*32-1:0]  evCntFlat,
  input  logic [63:0]            cycCnt,
  input  logic [31:0]            wrapVec,
  output dpStrobe_t              strobe,
  output logic [NUM_CNT*8-1:0]   evSelFlat,
  output logic [31:0]            cntActive,
  output logic [31:0]            cntEn,
  output logic [31:0]            irqEn,
  output logic [31:0]            ovfBits,
  output logic                   gEn,
  output logic                   irq
);
  localparam logic [31:0] IMPL_MASK = ((32'd1 << NUM_CNT) - 32'd1) | 32'h8000_0000;

  logic [4:0]  regIdx;
  logic        wrCtrl, rdOvf, selWr;
  logic [31:0] enSet, enClr, irqSet, irqClr, rdMux, cycHold;

  assign regIdx = regAddr[4:0];
  assign wrCtrl = regWrEn && (regAddr == ADR_CTRL);
  assign rdOvf  = regRdEn && (regAddr == ADR_OVF);
  assign selWr  = regWrEn && (regAddr[7:5] == REGION_SEL);
  assign enSet  = (regWrEn && regAddr == ADR_EN_SET)  ? (regWrData & IMPL_MASK) : '0;
  assign enClr  = (regWrEn && regAddr == ADR_EN_CLR)  ? regWrData : '0;
  assign irqSet = (regWrEn && regAddr == ADR_IRQ_SET) ? (regWrData & IMPL_MASK) : '0;
  assign irqClr = (regWrEn && regAddr == ADR_IRQ_CLR) ? regWrData : '0;

  always_comb begin
    strobe         = '0;
    strobe.wrData  = regWrData;
    strobe.cycLoWr = regWrEn && (regAddr == ADR_CYC_LO);
    strobe.cycHiWr = regWrEn && (regAddr == ADR_CYC_HI);
    strobe.rstEv   = wrCtrl && regWrData[1];
    strobe.rstCyc  = wrCtrl && regWrData[2];
    for (int i = 0; i < NUM_CNT; i++)
      strobe.evCntWr[i] = regWrEn && (regAddr[7:5] == REGION_CNT) && (regIdx == 5'(i));
  end

  assign cntActive = gEn ? cntEn : '0;
  assign irq       = |(ovfBits & irqEn);

  always_comb begin
    rdMux = '0;
    case (regAddr)
      ADR_CTRL:                rdMux = {IMPL_CODE, ID_CODE, 5'(NUM_CNT), 10'd0, gEn};
      ADR_EN_SET, ADR_EN_CLR:  rdMux = cntEn;
      ADR_IRQ_SET, ADR_IRQ_CLR: rdMux = irqEn;
      ADR_OVF:                 rdMux = ovfBits;
      ADR_CEID_LO:             rdMux = CEID_MASK[31:0];
      ADR_CEID_HI:             rdMux = CEID_MASK[63:32];
      ADR_CYC_LO:              rdMux = cycCnt[31:0];
      ADR_CYC_HI:              rdMux = cycHold;
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (regIdx == 5'(i) && regAddr[7:5] == REGION_CNT) rdMux = evCntFlat[i*32 +: 32];
          if (regIdx == 5'(i) && regAddr[7:5] == REGION_SEL) rdMux = {24'd0, evSelFlat[i*8 +: 8]};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gEn       <= 1'b0;
      cntEn     <= '0;
      irqEn     <= '0;
      ovfBits   <= '0;
      evSelFlat <= '0;
      cycHold   <= '0;
      regRdData <= '0;
    end else begin
      if (wrCtrl) gEn <= regWrData[0];
      cntEn   <= (cntEn | enSet) & ~enClr;
      irqEn   <= (irqEn | irqSet) & ~irqClr;
      ovfBits <= (rdOvf ? '0 : ovfBits) | (wrapVec & IMPL_MASK);
      for (int i = 0; i < NUM_CNT; i++)
        if (selWr && regIdx == 5'(i)) evSelFlat[i*8 +: 8] <= regWrData[7:0];
      if (regRdEn && regAddr == ADR_CYC_LO) cycHold <= cycCnt[63:32];
      if (regRdEn) regRdData <= rdMux;
    end
  end
endmodule

// File: rtl/perfmon_dp.sv
`timescale 1ns/1ps
module perfmon_dp
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 6,
  parameter int unsigned EVT_W   = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [NUM_CNT*8-1:0]  evSelFlat,
  input  logic [31:0]           cntActive,
  input  logic [EVT_W-1:0]      events,
  output logic [NUM_CNT*32-1:0] evCntFlat,
  output logic [63:0]           cycCnt,
  output logic [31:0]           wrapVec
);
  localparam int unsigned SEL_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

  logic [NUM_CNT-1:0] baseHit, chainHit, incV, evenWrap;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [31:0] cnt;
    logic [7:0]  sel;
    logic        evBit, full, wrBlock;
    assign sel     = evSelFlat[g*8 +: 8];
    assign evBit   = (32'(sel) < EVT_W) ? events[sel[SEL_W-1:0]] : 1'b0;
    assign baseHit[g] = (sel == EV_CYCLES) | ((sel != EV_CHAIN) & evBit);
    assign full    = &cnt;
    assign wrBlock = strobe.evCntWr[g] | strobe.rstEv;
    if (g % 2 == 1) begin : g_odd
      assign chainHit[g] = (sel == EV_CHAIN) & evenWrap[g-1];
      assign evenWrap[g] = 1'b0;
    end else begin : g_even
      assign chainHit[g] = 1'b0;
      assign evenWrap[g] = cntActive[g] & baseHit[g] & full & ~wrBlock;
    end
    assign incV[g]    = cntActive[g] & (baseHit[g] | chainHit[g]);
    assign wrapVec[g] = incV[g] & full & ~wrBlock;

    always_ff @(posedge clk) begin
      if (!rstN)                  cnt <= '0;
      else if (strobe.evCntWr[g]) cnt <= strobe.wrData;
      else if (strobe.rstEv)      cnt <= '0;
      else if (incV[g])           cnt <= cnt + 32'd1;
    end
    assign evCntFlat[g*32 +: 32] = cnt;
  end

  if (NUM_CNT < 31) begin : g_pad
    logic unusedBits;
    assign wrapVec[30:NUM_CNT] = '0;
    assign unusedBits = ^{cntActive[30:NUM_CNT], strobe.evCntWr[30:NUM_CNT]};
  end

  logic cycInc, cycBlock;
  assign cycInc   = cntActive[CYC_IDX];
  assign cycBlock = strobe.cycLoWr | strobe.cycHiWr | strobe.rstCyc;
  assign wrapVec[CYC_IDX] = cycInc & (&cycCnt) & ~cycBlock;

  always_ff @(posedge clk) begin
    if (!rstN)               cycCnt <= '0;
    else if (strobe.rstCyc)  cycCnt <= '0;
    else if (cycBlock) begin
      if (strobe.cycLoWr) cycCnt[31:0]  <= strobe.wrData;
      if (strobe.cycHiWr) cycCnt[63:32] <= strobe.wrData;
    end else if (cycInc)     cycCnt <= cycCnt + 64'd1;
  end
endmodule

// File: rtl/clu_perfmon.sv
`timescale 1ns/1ps
module clu_perfmon
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT   = 6,
  parameter int unsigned EVT_W     = 64,
  parameter logic [7:0]  ID_CODE   = 8'h5A,
  parameter logic [7:0]  IMPL_CODE = 8'h41,
  parameter logic [63:0] CEID_MASK = 64'h0000_1E00_6602_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [EVT_W-1:0] events,
  output logic             irq
);
  dpStrobe_t             strobe;
  logic [NUM_CNT*8-1:0]  evSelFlat;
  logic [NUM_CNT*32-1:0] evCntFlat;
  logic [63:0]           cycCnt;
  logic [31:0]           wrapVec, cntActive, cntEn, irqEn, ovfBits;
  logic                  gEn;

  perfmon_ctrl #(
    .NUM_CNT(NUM_CNT), .ID_CODE(ID_CODE), .IMPL_CODE(IMPL_CODE), .CEID_MASK(CEID_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evCntFlat(evCntFlat), .cycCnt(cycCnt),
    .wrapVec(wrapVec), .strobe(strobe), .evSelFlat(evSelFlat), .cntActive(cntActive),
    .cntEn(cntEn), .irqEn(irqEn), .ovfBits(ovfBits), .gEn(gEn), .irq(irq)
  );

  perfmon_dp #(.NUM_CNT(NUM_CNT), .EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evSelFlat(evSelFlat), .cntActive(cntActive),
    .events(events), .evCntFlat(evCntFlat), .cycCnt(cycCnt), .wrapVec(wrapVec)
  );
endmodule

// File: rtl/perfmon_chk.sv
`timescale 1ns/1ps
module perfmon_chk
  import perfmon_pkg::*;
#(
  parameter int unsigned NUM_CNT = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  regRdEn,
  input logic [7:0]            regAddr,
  input logic [31:0]           regRdData,
  input logic [31:0]           ovfBits,
  input logic [31:0]           wrapVec,
  input logic [31:0]           cntEn,
  input logic [NUM_CNT*32-1:0] evCntFlat,
  input logic                  gEn
);
  localparam logic [31:0] IMPL_MASK = ((32'd1 << NUM_CNT) - 32'd1) | 32'h8000_0000;

  AST_OVF_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADR_OVF) |=> ((ovfBits & ~$past(wrapVec)) == 32'd0)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regAddr == ADR_OVF) |=> ((ovfBits & $past(ovfBits)) == $past(ovfBits))); // R7

  AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADR_CTRL) |=> (regRdData[15:11] == 5'(NUM_CNT))); // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!gEn && !regWrEn) |=> $stable(evCntFlat)); // R2

  AST_UNIMPL_EN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((cntEn & ~IMPL_MASK) == 32'd0)); // R4
endmodule

bind clu_perfmon perfmon_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .ovfBits(ovfBits), .wrapVec(wrapVec), .cntEn(cntEn),
  .evCntFlat(evCntFlat), .gEn(gEn)
);

// File: tb/tb_clu_perfmon.sv
`timescale 1ns/1ps
module tb_clu_perfmon;
  localparam int unsigned N = 4;
  localparam logic [7:0]  TB_ID   = 8'h3C;
  localparam logic [7:0]  TB_IMPL = 8'h7E;
  localparam logic [63:0] TB_CEID = 64'h0000_3C00_6E02_8001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] events = '0;
  logic        irq;
  int          checks = 0, fails = 0;
  logic [31:0] rv;

  clu_perfmon #(.NUM_CNT(N), .EVT_W(64), .ID_CODE(TB_ID), .IMPL_CODE(TB_IMPL),
                .CEID_MASK(TB_CEID)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .events(events), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks are entered just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic pulse(input int idx, input int k);
    events[idx] = 1'b1;
    repeat (k) @(negedge clk);
    events[idx] = 1'b0;
  endtask

  task automatic t_reset_state;
    rd(8'h00, rv); chk("R1 ctrl after reset", rv, {TB_IMPL, TB_ID, 5'(N), 11'd0});
    rd(8'h05, rv); chk("R8 ovf after reset", rv, 0);
    chk("R9 irq after reset", irq, 0);
  endtask

  task automatic t_ceid;
    rd(8'h06, rv); chk("R13 ceid low", rv, TB_CEID[31:0]);
    rd(8'h07, rv); chk("R13 ceid high", rv, TB_CEID[63:32]);
  endtask

  task automatic t_masks;
    wr(8'h01, 32'hFFFF_FFFF); rd(8'h01, rv); chk("R4 enable clipped", rv, 32'h8000_000F);
    wr(8'h02, 32'h0000_0002); rd(8'h02, rv); chk("R4 enable clear", rv, 32'h8000_000D);
    wr(8'h03, 32'h8000_0041); rd(8'h03, rv); chk("R4 irq enable set", rv, 32'h8000_0001);
    wr(8'h02, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); chk("R4 irq enable cleared", rv, 0);
  endtask

  task automatic t_unimpl;
    wr(8'h25, 32'h0000_ABCD); rd(8'h25, rv); chk("R14 counter 5 absent", rv, 0);
    wr(8'h45, 32'h0000_0005); rd(8'h45, rv); chk("R14 select 5 absent", rv, 0);
    wr(8'h23, 32'h0000_1111); rd(8'h23, rv); chk("R10 direct write", rv, 32'h1111);
  endtask

  task automatic t_count;
    wr(8'h40, 8'h05); wr(8'h41, 8'h06); wr(8'h42, 8'h05);
    rd(8'h42, rv); chk("R2 select readback", rv, 5);
    wr(8'h20, 32'h7FFF_FFFF); wr(8'h21, 0); wr(8'h22, 0);
    wr(8'h01, 32'h3);
    wr(8'h00, 32'h1);
    rd(8'h00, rv); chk("R1 enable bit reads", rv[0], 1);
    pulse(5, 4);
    wr(8'h00, 32'h0);
    rd(8'h20, rv); chk("R10 count from written value", rv, 32'h8000_0003);
    rd(8'h21, rv); chk("R2 unselected event", rv, 0);
    rd(8'h22, rv); chk("R2 counter not enabled", rv, 0);
    pulse(5, 3);
    rd(8'h20, rv); chk("R2 global enable off", rv, 32'h8000_0003);
  endtask

  task automatic t_cycle_event;
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h43, 8'h11); wr(8'h23, 0); wr(8'h01, 32'h8);
    wr(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h23, rv); chk("R5 cycle event code", rv, 5);
  endtask

  task automatic t_chain;
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h40, 8'h05); wr(8'h41, 8'h1E);
    wr(8'h20, 32'hFFFF_FFFE); wr(8'h21, 0);
    wr(8'h01, 32'h3);
    wr(8'h00, 32'h1);
    pulse(5, 3);
    wr(8'h00, 32'h0);
    rd(8'h20, rv); chk("R7 32-bit wrap", rv, 1);
    rd(8'h21, rv); chk("R6 chain carry", rv, 1);
    chk("R9 irq masked", irq, 0);
    wr(8'h03, 32'h1);
    chk("R9 irq raised", irq, 1);
    rd(8'h05, rv); chk("R8 ovf read value", rv, 32'h1);
    chk("R8 irq drops after read", irq, 0);
    rd(8'h05, rv); chk("R8 ovf cleared", rv, 0);
  endtask

  task automatic t_cycle_counter;
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFD); wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h01, 32'h8000_0000); wr(8'h03, 32'h8000_0000);
    wr(8'h00, 32'h1);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'h0);
    chk("R9 irq from cycle wrap", irq, 1);
    rd(8'h08, rv); chk("R3 cycle low wrapped", rv, 0);
    rd(8'h09, rv); chk("R3 cycle high wrapped", rv, 0);
    rd(8'h05, rv); chk("R3 ovf bit 31", rv, 32'h8000_0000);
    wr(8'h08, 32'h5); wr(8'h09, 32'h7);
    rd(8'h08, rv); chk("R12 low half", rv, 5);
    wr(8'h09, 32'h9);
    rd(8'h09, rv); chk("R12 held high half", rv, 7);
    rd(8'h08, rv);
    rd(8'h09, rv); chk("R12 recaptured high half", rv, 9);
  endtask

  task automatic t_resets;
    wr(8'h22, 32'h1234); wr(8'h08, 32'h55);
    wr(8'h00, 32'h4);
    rd(8'h08, rv); chk("R11 cycle cleared", rv, 0);
    rd(8'h22, rv); chk("R11 events kept", rv, 32'h1234);
    wr(8'h00, 32'h2);
    rd(8'h22, rv); chk("R11 events cleared", rv, 0);
    rd(8'h00, rv); chk("R1 low bits read zero", rv[2:0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_ceid();
    t_masks();
    t_unimpl();
    t_count();
    t_cycle_event();
    t_chain();
    t_cycle_counter();
    t_resets();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule